// File: doc/BRIEF.md
# Latched Parity Bus Transceiver

This block joins two 9-bit buses, side A and side B, each made of 8 data bits and one parity bit. Two active-low output enables pick the direction: the source side's word passes through that side's latch and is driven onto the other side. A mode input chooses what happens to the parity bit on the way. In generate mode the block computes a fresh parity bit from the source data. In feed-through mode it passes the incoming parity bit on unchanged. A second input chooses odd or even parity.

Each side stores its bus word in a level-sensitive latch with its own enable. Each side also has an active-low error flag that judges the word held in that side's latch. The flags work in every mode, so the source flag reports bad incoming parity even in feed-through mode. The pads are split into separate input, output and output-enable signals. When a side is driven, its pad input carries the driven word back into that side's latch. With the destination latch open, the destination flag therefore judges the word actually placed on the bus, and both flags are valid together.

All paths are combinational or pass through latches. There is no clock.

Top module: `lpx_xcvr`

## Requirements
- R1: The enables select the direction. With `oe_b_n`=0 and `oe_a_n`=1, side B is driven from side A (`b_oe`=1, `a_oe`=0). With `oe_a_n`=0 and `oe_b_n`=1, side A is driven from side B (`a_oe`=1, `b_oe`=0). With both enables high, neither side is driven.
- R2: With both `oe_a_n` and `oe_b_n` low, `conflict` is 1 and neither `a_oe` nor `b_oe` is 1. In every other case `conflict` is 0.
- R3: When `feed_thru`=0, the driven parity bit is generated from the source latch data. With `parity_odd`=1, the driven 9-bit word holds an odd number of ones. With `parity_odd`=0, it holds an even number.
- R4: When `feed_thru`=1, the driven parity bit equals the parity bit stored in the source latch.
- R5: The driven data bits equal the data bits stored in the source latch.
- R6: A latch with its enable at 1 follows its pad input, both data and parity. With its enable at 0, it keeps the word it held when the enable fell, whatever its pad input does afterwards.
- R7: Each error flag is 1 when the ones count of that side's stored 9-bit word has the parity selected by `parity_odd`, and 0 otherwise. This holds in every direction and in both parity modes, feed-through included.
- R8: While the destination latch is open, the destination flag judges the driven word. In generate mode the destination flag is 1 even when the source flag is 0. In feed-through mode with bad source parity, both flags are 0.
- R9: While `rst_n` is 0, both latches hold data 0 and a parity bit equal to `parity_odd`, so both flags are 1. Once `rst_n` rises, a closed latch keeps that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset of both latches |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| feed_thru | input | 1 | 1 passes the source parity bit on unchanged, 0 generates a new one |
| oe_a_n | input | 1 | Active-low enable for driving side A |
| oe_b_n | input | 1 | Active-low enable for driving side B |
| le_a | input | 1 | Side A latch transparent when 1 |
| le_b | input | 1 | Side B latch transparent when 1 |
| a_in | input | 8 | Side A pad data input |
| a_par_in | input | 1 | Side A pad parity input |
| a_out | output | 8 | Side A driven data |
| a_par_out | output | 1 | Side A driven parity |
| a_oe | output | 1 | Side A pad output enable |
| b_in | input | 8 | Side B pad data input |
| b_par_in | input | 1 | Side B pad parity input |
| b_out | output | 8 | Side B driven data |
| b_par_out | output | 1 | Side B driven parity |
| b_oe | output | 1 | Side B pad output enable |
| err_a_n | output | 1 | Side A parity error flag, 0 on error |
| err_b_n | output | 1 | Side B parity error flag, 0 on error |
| conflict | output | 1 | 1 when both enables request a drive |

## Verification
Every result is due in the same step as the stimulus that causes it, because no path through the block crosses a clock edge. The bench lets each input change settle for 2 ns before it updates its model or samples anything. Each vector is applied in three separate steps: first the latch enables, then the mode and direction controls, then the pad data. A latch that closes therefore never races the data it is meant to hold. After each step the bench's pad model returns the expected driven word to the destination pad input, as a tri-state bus would.

// File: rtl/lpx_pkg.sv
package lpx_pkg;
  parameter int unsigned LPX_DW = 8;

  typedef enum logic [1:0] {
    LPX_IDLE  = 2'd0,
    LPX_A2B   = 2'd1,
    LPX_B2A   = 2'd2,
    LPX_CLASH = 2'd3
  } lpx_dir_e;
endpackage

// File: rtl/lpx_dir_decode.sv
module lpx_dir_decode
  import lpx_pkg::*;
(
  input  logic     oe_a_n,
  input  logic     oe_b_n,
  output lpx_dir_e dir,
  output logic     a_oe,
  output logic     b_oe,
  output logic     conflict
);
  always_comb begin
    unique case ({oe_a_n, oe_b_n})
      2'b11:   dir = LPX_IDLE;
      2'b10:   dir = LPX_A2B;
      2'b01:   dir = LPX_B2A;
      default: dir = LPX_CLASH;
    endcase
  end

  assign a_oe     = (dir == LPX_B2A);
  assign b_oe     = (dir == LPX_A2B);
  assign conflict = (dir == LPX_CLASH);

  always_comb begin
    AST_SINGLE_DRIVER: assert (!(a_oe && b_oe)); // R2
    AST_CLASH_QUIET: assert (!(conflict && (a_oe || b_oe))); // R2
    AST_CLASH_PINS: assert (conflict == (!oe_a_n && !oe_b_n)); // R2
    AST_B_DRIVE_MAP: assert (b_oe == (oe_a_n && !oe_b_n)); // R1
    AST_A_DRIVE_MAP: assert (a_oe == (!oe_a_n && oe_b_n)); // R1
  end
endmodule

// File: rtl/lpx_word_latch.sv
module lpx_word_latch #(
  parameter int unsigned DW = 8
) (
  input  logic          rst_n,
  input  logic          le,
  input  logic          reset_par,
  input  logic [DW-1:0] d_data,
  input  logic          d_par,
  output logic [DW-1:0] q_data,
  output logic          q_par
);
  always_latch begin
    if (!rst_n) begin
      q_data = '0;
      q_par  = reset_par;
    end else if (le) begin
      q_data = d_data;
      q_par  = d_par;
    end
  end
endmodule

// File: rtl/lpx_parity_unit.sv
module lpx_parity_unit #(
  parameter int unsigned DW = 8
) (
  input  logic          odd,
  input  logic [DW-1:0] data,
  input  logic          par,
  output logic          gen_par,
  output logic          match
);
  assign gen_par = (^data) ^ odd;
  assign match   = (gen_par == par);
endmodule

// File: rtl/lpx_xcvr.sv
module lpx_xcvr
  import lpx_pkg::*;
#(
  parameter int unsigned DW = LPX_DW
) (
  input  logic          rst_n,
  input  logic          parity_odd,
  input  logic          feed_thru,
  input  logic          oe_a_n,
  input  logic          oe_b_n,
  input  logic          le_a,
  input  logic          le_b,
  input  logic [DW-1:0] a_in,
  input  logic          a_par_in,
  output logic [DW-1:0] a_out,
  output logic          a_par_out,
  output logic          a_oe,
  input  logic [DW-1:0] b_in,
  input  logic          b_par_in,
  output logic [DW-1:0] b_out,
  output logic          b_par_out,
  output logic          b_oe,
  output logic          err_a_n,
  output logic          err_b_n,
  output logic          conflict
);
  localparam int unsigned NSIDE = 2;

  lpx_dir_e                  dir;
  logic [NSIDE-1:0][DW-1:0]  pad_d, q_d, drv_d;
  logic [NSIDE-1:0]          pad_p, q_p, gen_p, ok, le_v, drv_p;

  lpx_dir_decode u_dec (
    .oe_a_n   (oe_a_n),
    .oe_b_n   (oe_b_n),
    .dir      (dir),
    .a_oe     (a_oe),
    .b_oe     (b_oe),
    .conflict (conflict)
  );

  assign pad_d = {b_in, a_in};
  assign pad_p = {b_par_in, a_par_in};
  assign le_v  = {le_b, le_a};

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    localparam int SRC = NSIDE - 1 - s;

    lpx_word_latch #(.DW(DW)) u_lat (
      .rst_n     (rst_n),
      .le        (le_v[s]),
      .reset_par (parity_odd),
      .d_data    (pad_d[s]),
      .d_par     (pad_p[s]),
      .q_data    (q_d[s]),
      .q_par     (q_p[s])
    );

    lpx_parity_unit #(.DW(DW)) u_par (
      .odd     (parity_odd),
      .data    (q_d[s]),
      .par     (q_p[s]),
      .gen_par (gen_p[s]),
      .match   (ok[s])
    );

    assign drv_d[s] = q_d[SRC];
    assign drv_p[s] = feed_thru ? q_p[SRC] : gen_p[SRC];
  end

  assign a_out     = drv_d[0];
  assign a_par_out = drv_p[0];
  assign b_out     = drv_d[1];
  assign b_par_out = drv_p[1];
  assign err_a_n   = ok[0];
  assign err_b_n   = ok[1];

  always_comb begin
    if (rst_n && b_oe && !feed_thru)
      AST_GEN_WORD_B: assert ((^{b_out, b_par_out}) == parity_odd); // R3
    if (rst_n && a_oe && !feed_thru)
      AST_GEN_WORD_A: assert ((^{a_out, a_par_out}) == parity_odd); // R3
    if (rst_n && b_oe && feed_thru && le_a)
      AST_FEED_COPY_B: assert (b_par_out == a_par_in); // R4
    if (rst_n && a_oe && feed_thru && le_b)
      AST_FEED_COPY_A: assert (a_par_out == b_par_in); // R4
    if (rst_n && b_oe && le_a)
      AST_DATA_PASS_B: assert (b_out == a_in); // R5
    if (rst_n && le_a)
      AST_SRC_FLAG_A: assert (err_a_n == ((^{a_in, a_par_in}) == parity_odd)); // R7
    if (rst_n && le_b)
      AST_SRC_FLAG_B: assert (err_b_n == ((^{b_in, b_par_in}) == parity_odd)); // R7
    if (!rst_n)
      AST_RESET_FLAGS: assert (err_a_n && err_b_n); // R9
  end
endmodule

// File: tb/test_lpx_xcvr.sv
`timescale 1ns/1ps
module test_lpx_xcvr;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, parity_odd, feed_thru, oe_a_n, oe_b_n, le_a, le_b;
  logic [DW-1:0] a_in, b_in, a_out, b_out;
  logic          a_par_in, b_par_in, a_par_out, b_par_out, a_oe, b_oe;
  logic          err_a_n, err_b_n, conflict;

  lpx_xcvr #(.DW(DW)) i_lpx_xcvr (
    .rst_n(rst_n), .parity_odd(parity_odd), .feed_thru(feed_thru),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .le_a(le_a), .le_b(le_b),
    .a_in(a_in), .a_par_in(a_par_in), .a_out(a_out), .a_par_out(a_par_out), .a_oe(a_oe),
    .b_in(b_in), .b_par_in(b_par_in), .b_out(b_out), .b_par_out(b_par_out), .b_oe(b_oe),
    .err_a_n(err_a_n), .err_b_n(err_b_n), .conflict(conflict)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // external (non-driven) pad values and the reference latch contents
  logic [DW-1:0] a_ext, b_ext, ma_d, mb_d;
  logic          a_ext_p, b_ext_p, ma_p, mb_p;

  function automatic logic gen(input logic [DW-1:0] d, input logic odd);
    int c = 0;
    for (int i = 0; i < DW; i++) c += int'(d[i]);
    return (c % 2 == 1) ? ~odd : odd;
  endfunction

  function automatic logic flag(input logic [DW-1:0] d, input logic p, input logic odd);
    return gen(d, odd) == p;
  endfunction

  function automatic logic drive_par(input logic [DW-1:0] d, input logic p);
    return feed_thru ? p : gen(d, parity_odd);
  endfunction

  // model one settling of the block plus the bus pad feedback, then drive the pads
  task automatic settle();
    logic ab, ba;
    ab = !oe_b_n && oe_a_n;
    ba = !oe_a_n && oe_b_n;
    a_in = a_ext; a_par_in = a_ext_p;
    b_in = b_ext; b_par_in = b_ext_p;
    if (!rst_n) begin
      ma_d = '0; ma_p = parity_odd; mb_d = '0; mb_p = parity_odd;
      if (ab) begin b_in = ma_d; b_par_in = drive_par(ma_d, ma_p); end
      if (ba) begin a_in = mb_d; a_par_in = drive_par(mb_d, mb_p); end
    end else if (ab) begin
      if (le_a) begin ma_d = a_in; ma_p = a_par_in; end
      b_in = ma_d; b_par_in = drive_par(ma_d, ma_p);
      if (le_b) begin mb_d = b_in; mb_p = b_par_in; end
    end else if (ba) begin
      if (le_b) begin mb_d = b_in; mb_p = b_par_in; end
      a_in = mb_d; a_par_in = drive_par(mb_d, mb_p);
      if (le_a) begin ma_d = a_in; ma_p = a_par_in; end
    end else begin
      if (le_a) begin ma_d = a_in; ma_p = a_par_in; end
      if (le_b) begin mb_d = b_in; mb_p = b_par_in; end
    end
    #2;
  endtask

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // compare every port against the model; tag "" selects per-field tags
  task automatic check_all(input string tag);
    logic ab, ba, clash;
    ab    = !oe_b_n && oe_a_n;
    ba    = !oe_a_n && oe_b_n;
    clash = !oe_a_n && !oe_b_n;
    chk(tag == "" ? "R1" : tag, "b_oe", 16'(b_oe), 16'(ab));
    chk(tag == "" ? "R1" : tag, "a_oe", 16'(a_oe), 16'(ba));
    chk(tag == "" ? "R2" : tag, "conflict", 16'(conflict), 16'(clash));
    chk(tag == "" ? "R7" : tag, "err_a_n", 16'(err_a_n), 16'(flag(ma_d, ma_p, parity_odd)));
    chk(tag == "" ? "R7" : tag, "err_b_n", 16'(err_b_n), 16'(flag(mb_d, mb_p, parity_odd)));
    if (ab) begin
      chk(tag == "" ? "R5" : tag, "b_out", 16'(b_out), 16'(ma_d));
      chk(tag == "" ? (feed_thru ? "R4" : "R3") : tag, "b_par_out",
          16'(b_par_out), 16'(drive_par(ma_d, ma_p)));
    end
    if (ba) begin
      chk(tag == "" ? "R5" : tag, "a_out", 16'(a_out), 16'(mb_d));
      chk(tag == "" ? (feed_thru ? "R4" : "R3") : tag, "a_par_out",
          16'(a_par_out), 16'(drive_par(mb_d, mb_p)));
    end
  endtask

  // three-step application: latch enables, then controls, then pad data
  task automatic apply(input logic la, input logic lb, input logic odd, input logic ft,
                       input logic oea, input logic oeb,
                       input logic [DW-1:0] ad, input logic ap,
                       input logic [DW-1:0] bd, input logic bp);
    le_a = la; le_b = lb; settle();
    parity_odd = odd; feed_thru = ft; oe_a_n = oea; oe_b_n = oeb; settle();
    a_ext = ad; a_ext_p = ap; b_ext = bd; b_ext_p = bp; settle();
  endtask

  task automatic t_reset();
    rst_n = 0; apply(0, 0, 1, 0, 1, 0, 8'hA5, 0, 8'h3C, 1);
    check_all("R9");
    chk("R9", "b_out in reset", 16'(b_out), 16'h0);
    chk("R9", "b_par_out in reset", 16'(b_par_out), 16'h1);
    rst_n = 1; settle();
    apply(0, 0, 1, 1, 1, 0, 8'h77, 1, 8'h12, 0);
    check_all("R9");
    chk("R9", "held parity after reset", 16'(b_par_out), 16'h1);
    chk("R9", "err_a_n after reset", 16'(err_a_n), 16'h1);
  endtask

  task automatic t_sweep();
    for (int odd = 0; odd < 2; odd++)
      for (int row = 0; row < 32; row++)
        for (int k = 0; k < 4; k++) begin
          logic [DW-1:0] ad, bd;
          ad = DW'(row * 37 + k * 91 + odd * 13 + 5);
          bd = DW'(row * 53 + k * 29 + 200);
          apply(row[0], row[1], odd[0], row[2], row[3], row[4],
                ad, gen(ad, odd[0]) ^ k[0], bd, gen(bd, odd[0]) ^ k[1]);
          check_all("");
        end
  endtask

  task automatic t_hold();
    apply(1, 1, 0, 1, 1, 0, 8'h5A, 1, 8'h00, 0);
    apply(0, 1, 0, 1, 1, 0, 8'h5A, 1, 8'h00, 0);
    apply(0, 1, 0, 1, 1, 0, 8'hC3, 0, 8'hFF, 1);
    check_all("R6");
    chk("R6", "held b_out", 16'(b_out), 16'h5A);
    chk("R6", "held b_par_out", 16'(b_par_out), 16'h1);
  endtask

  task automatic t_both_flags();
    // 0x01 with parity 1 has an even ones count: bad under odd parity
    apply(1, 1, 1, 1, 0, 1, 8'h00, 0, 8'h01, 1);
    check_all("R8");
    chk("R8", "feed err_b_n", 16'(err_b_n), 16'h0);
    chk("R8", "feed err_a_n", 16'(err_a_n), 16'h0);
    apply(1, 1, 1, 0, 0, 1, 8'h00, 0, 8'h01, 1);
    check_all("R8");
    chk("R8", "gen err_b_n", 16'(err_b_n), 16'h0);
    chk("R8", "gen err_a_n", 16'(err_a_n), 16'h1);
  endtask

  task automatic t_conflict();
    apply(1, 1, 0, 0, 0, 0, 8'h81, 0, 8'h18, 1);
    check_all("R2");
    chk("R2", "conflict", 16'(conflict), 16'h1);
    chk("R2", "no drive", 16'({a_oe, b_oe}), 16'h0);
  endtask

  initial begin
    rst_n = 0; parity_odd = 0; feed_thru = 0; oe_a_n = 1; oe_b_n = 1;
    le_a = 0; le_b = 0; a_ext = '0; b_ext = '0; a_ext_p = 0; b_ext_p = 0;
    ma_d = '0; mb_d = '0; ma_p = 0; mb_p = 0;
    a_in = '0; b_in = '0; a_par_in = 0; b_par_in = 0;
    @(negedge clk);
    t_reset();
    t_sweep();
    t_hold();
    t_both_flags();
    t_conflict();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule